// File: doc/BRIEF.md
# Password-Gated Memory Security Gate

This block guards a fixed set of on-chip memory ranges behind a 128-bit password held in nonvolatile storage. After reset it is locked: any access from code that is not itself running in a guarded range reads back zero from a guarded address, and any write it makes there is dropped. Accesses to addresses outside the guarded ranges always pass.

To unlock, software writes the key as eight 16-bit words into key registers and then sets a compare bit in a control register. The block reads the stored password over a wide read port and compares all 128 bits. It unlocks if the key matches the stored password. It also unlocks if the stored password is all ones, which is the state of erased storage. A compare can start at most once every two clock cycles. A relock command locks the block again and wipes the key registers.

Top module: `mem_guard`

## Requirements
- R1: After synchronous reset the block is locked. The status register (register address 8) reads 0, and all key words are 0.
- R2: Key word i (register addresses 0 to 7) holds key bits [16i+15:16i]. Reading any key address returns 0.
- R3: Writing address 8 with bit 0 set starts a compare. pw_rd is high in the cycle after the accepting edge. pw_data is sampled one cycle later. The result shows on status bit 0 after the second edge following the accepting edge. A match of all 128 bits unlocks.
- R4: If any single key word differs from the stored password, the block stays locked.
- R5: A stored password of all ones unlocks the block whatever the key.
- R6: A compare request is ignored while pw_rd is high. A request arriving in the evaluation cycle is accepted. pw_rd is never high in two consecutive cycles.
- R7: Writing address 8 with bit 1 set locks the block, clears all key words and aborts a running compare. This happens even when bit 0 is also set in the same write, or when the write lands in the evaluation cycle.
- R8: The guarded ranges are 0x008000-0x008FFF, 0x009000-0x009FFF, 0x3D7800-0x3D7BFF and 0x3D8000-0x3F7FFF. No address lies in more than one of them.
- R9: While locked, an access to a guarded address with acc_secure low gives acc_rdata = 0, mem_wr = 0 and acc_grant = 0.
- R10: An access passes (acc_grant = 1, acc_rdata = mem_rdata, mem_wr = acc_wr) when it is outside all guarded ranges, or acc_secure is high, or the block is unlocked.
- R11: Status bit 0 is the unlocked flag. Status bit 1 is high while a compare is fetching or evaluating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0-7 key words, 8 control/status) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pw_rd | output | 1 | Password read request |
| pw_data | input | 128 | Stored password, valid the cycle after pw_rd |
| acc_addr | input | 22 | Memory access word address |
| acc_wr | input | 1 | Memory write request |
| acc_secure | input | 1 | Access issued by code running in a guarded range |
| mem_rdata | input | 16 | Read data from memory |
| acc_rdata | output | 16 | Read data returned to the requester |
| mem_wr | output | 1 | Write enable passed to memory |
| acc_grant | output | 1 | Access allowed |

## Verification
Two functions can coincide. The first case is a relock command that lands in the same cycle as a compare's evaluation step. The bench provokes it by writing a correct key, triggering a compare, and placing the relock write exactly two edges later; the block must end locked with the key cleared. The second case is a guarded access issued in the cycle just before the unlocking edge. It must still be blocked, because the gate uses the registered flag, and the same access one cycle later must pass.

// File: rtl/mg_pkg.sv
package mg_pkg;

    localparam int WORD_W      = 16;
    localparam int KEY_WORDS   = 8;
    localparam int KEY_W       = WORD_W * KEY_WORDS;
    localparam int ADDR_W      = 22;
    localparam int RA_W        = 4;
    localparam int CTRL_ADDR   = 8;
    localparam int NUM_REGIONS = 4;

    typedef enum logic [1:0] {
        CMP_IDLE  = 2'd0,
        CMP_FETCH = 2'd1,
        CMP_EVAL  = 2'd2
    } cmp_state_e;

    typedef struct packed {
        logic relock;
        logic compare;
    } ctrl_cmd_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } region_t;

    localparam region_t REGION_MAP [NUM_REGIONS] = '{
        '{lo: 22'h008000, hi: 22'h008FFF},
        '{lo: 22'h009000, hi: 22'h009FFF},
        '{lo: 22'h3D7800, hi: 22'h3D7BFF},
        '{lo: 22'h3D8000, hi: 22'h3F7FFF}
    };

    function automatic ctrl_cmd_t decode_ctrl(input logic [WORD_W-1:0] w);
        ctrl_cmd_t c;
        c.compare = w[0];
        c.relock  = w[1];
        return c;
    endfunction

    function automatic logic in_region(input logic [ADDR_W-1:0] a, input region_t r);
        return (a >= r.lo) && (a <= r.hi);
    endfunction

endpackage

// File: rtl/mg_key_bank.sv
module mg_key_bank
    import mg_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int N_WORD = KEY_WORDS,
    parameter int A_W    = RA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [A_W-1:0]           addr,
    input  logic [W_WORD-1:0]        wdata,
    input  logic                     clear,
    output logic [W_WORD*N_WORD-1:0] key_out
);

    logic [W_WORD-1:0] words [N_WORD];

    for (genvar i = 0; i < N_WORD; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                words[i] <= '0;
            end else if (wr && (addr == A_W'(i))) begin
                words[i] <= wdata;
            end
        end
        assign key_out[i*W_WORD +: W_WORD] = words[i];
    end

    // R7: a clear empties every word by the next cycle
    a_r7_key_wiped: assert property (@(posedge clk) disable iff (rst)
        clear |=> (key_out == '0));

    // R1: key starts out empty after reset
    a_r1_key_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (key_out == '0));

endmodule

// File: rtl/mg_unlock_fsm.sv
module mg_unlock_fsm
    import mg_pkg::*;
#(
    parameter int W_KEY = KEY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             relock,
    input  logic [W_KEY-1:0] key,
    input  logic [W_KEY-1:0] pw_data,
    output logic             pw_rd,
    output logic             busy,
    output logic             unlocked
);

    cmp_state_e state;
    logic       match;

    assign match = (key == pw_data) || (&pw_data);

    always_ff @(posedge clk) begin
        if (rst || relock) begin
            state    <= CMP_IDLE;
            unlocked <= 1'b0;
        end else begin
            unique case (state)
                CMP_IDLE:  if (start) state <= CMP_FETCH;
                CMP_FETCH: state <= CMP_EVAL;
                CMP_EVAL: begin
                    unlocked <= unlocked | match;
                    state    <= start ? CMP_FETCH : CMP_IDLE;
                end
                default:   state <= CMP_IDLE;
            endcase
        end
    end

    assign pw_rd = (state == CMP_FETCH);
    assign busy  = (state != CMP_IDLE);

    // R1: locked right after reset
    a_r1_locked_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !unlocked);

    // R3: unlocking only ever follows an evaluation step
    a_r3_unlock_from_eval: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(state == CMP_EVAL));

    // R6: a fetch is always followed by evaluation unless relocked
    a_r6_fetch_then_eval: assert property (@(posedge clk) disable iff (rst)
        (pw_rd && !relock) |=> (state == CMP_EVAL));

    // R6: no two password reads in a row
    a_r6_spaced_reads: assert property (@(posedge clk) disable iff (rst)
        pw_rd |=> !pw_rd);

    // R7: relock always wins
    a_r7_relock_locks: assert property (@(posedge clk) disable iff (rst)
        relock |=> (!unlocked && !busy));

endmodule

// File: rtl/mg_region_decode.sv
module mg_region_decode
    import mg_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int N_REG = NUM_REGIONS
) (
    input  logic [A_W-1:0] addr,
    output logic [N_REG-1:0] hit_vec,
    output logic           hit
);

    for (genvar r = 0; r < N_REG; r++) begin : g_region
        assign hit_vec[r] = in_region(addr, REGION_MAP[r]);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/mem_guard.sv
module mem_guard
    import mg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              pw_rd,
    input  logic [KEY_W-1:0]  pw_data,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              acc_secure,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] acc_rdata,
    output logic              mem_wr,
    output logic              acc_grant
);

    ctrl_cmd_t              cmd;
    logic                   ctrl_wr, key_wr, start, relock;
    logic [KEY_W-1:0]       key;
    logic                   busy, unlocked;
    logic [NUM_REGIONS-1:0] hit_vec;
    logic                   hit;

    assign cmd     = decode_ctrl(reg_wdata);
    assign ctrl_wr = reg_wr && (reg_addr == RA_W'(CTRL_ADDR));
    assign key_wr  = reg_wr && (reg_addr < RA_W'(KEY_WORDS));
    assign relock  = ctrl_wr && cmd.relock;
    assign start   = ctrl_wr && cmd.compare && !cmd.relock;

    mg_key_bank u_keys (
        .clk     (clk),
        .rst     (rst),
        .wr      (key_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .clear   (relock),
        .key_out (key)
    );

    mg_unlock_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .relock   (relock),
        .key      (key),
        .pw_data  (pw_data),
        .pw_rd    (pw_rd),
        .busy     (busy),
        .unlocked (unlocked)
    );

    mg_region_decode u_dec (
        .addr    (acc_addr),
        .hit_vec (hit_vec),
        .hit     (hit)
    );

    assign reg_rdata = (reg_addr == RA_W'(CTRL_ADDR)) ?
                       {{(WORD_W-2){1'b0}}, busy, unlocked} : '0;

    assign acc_grant = !hit || unlocked || acc_secure;
    assign acc_rdata = acc_grant ? mem_rdata : '0;
    assign mem_wr    = acc_wr && acc_grant;

    // R8: guarded ranges never overlap
    a_r8_one_region: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R9: locked, unsecured writes into a guarded range are dropped
    a_r9_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && hit && !unlocked && !acc_secure) |-> !mem_wr);

    // R10: unguarded addresses see memory data unchanged
    a_r10_outside_passes: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (acc_rdata == mem_rdata));

endmodule

// File: tb/mem_guard_tb_top.sv
`timescale 1ns/1ps
module mem_guard_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         pw_rd;
    logic [127:0] pw_data = '0;
    logic [21:0]  acc_addr = '0;
    logic         acc_wr = 1'b0;
    logic         acc_secure = 1'b0;
    logic [15:0]  mem_rdata = 16'hBEEF;
    logic [15:0]  acc_rdata;
    logic         mem_wr;
    logic         acc_grant;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    mem_guard dut_i (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'd8;
    endtask

    task automatic load_key(input logic [127:0] k);
        for (int i = 0; i < 8; i++) wr_reg(4'(i), k[i*16 +: 16]);
    endtask

    function automatic logic [15:0] status_now();
        return reg_rdata;
    endfunction

    function automatic logic exp_hit(input logic [21:0] a);
        return (a >= 22'h008000 && a <= 22'h009FFF) ||
               (a >= 22'h3D7800 && a <= 22'h3D7BFF) ||
               (a >= 22'h3D8000 && a <= 22'h3F7FFF);
    endfunction

    task automatic check_access(input logic [21:0] a, input logic w, input logic sec,
                                input logic unl, input string req);
        logic g;
        acc_addr = a; acc_wr = w; acc_secure = sec; mem_rdata = 16'(a ^ 22'h1A5);
        #1;
        g = !exp_hit(a) || sec || unl;
        chk(req, {acc_grant, mem_wr, acc_rdata},
            {g, w & g, g ? 16'(a ^ 22'h1A5) : 16'h0});
        acc_wr = 1'b0; acc_secure = 1'b0;
    endtask

    // compare after loading key; returns at negedge where result is visible
    task automatic run_compare(input logic [127:0] k);
        load_key(k);
        wr_reg(4'd8, 16'h0001);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    logic [21:0] bnd [16];

    initial begin
        logic [127:0] pw, k;
        logic         exp_unl;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        reg_addr = 4'd8;
        #1;
        // R1: reset state
        chk("R1 status", status_now(), 16'h0);
        check_access(22'h008010, 1'b1, 1'b0, 1'b0, "R9 locked after reset");

        // R2: key reads give zero
        wr_reg(4'd3, 16'hA5A5);
        reg_addr = 4'd3; #1;
        chk("R2 key read", reg_rdata, 16'h0);
        reg_addr = 4'd8;

        // R3: basic unlock with timing
        pw = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        pw_data = pw;
        load_key(pw);
        wr_reg(4'd8, 16'h0001);
        chk("R3 pw_rd after trigger", pw_rd, 1'b1);
        chk("R11 busy while fetching", status_now(), 16'h2);
        // R13-like same cycle: guarded access in evaluation cycle still blocked
        @(negedge clk);
        chk("R3 pw_rd drops", pw_rd, 1'b0);
        check_access(22'h3D9000, 1'b0, 1'b0, 1'b0, "R9 blocked before unlock edge");
        @(negedge clk);
        chk("R3 unlocked", status_now(), 16'h1);
        check_access(22'h3D9000, 1'b1, 1'b0, 1'b1, "R10 unlocked passes");

        // R7: relock clears keys, then compare with cleared key fails
        wr_reg(4'd8, 16'h0002);
        #1;
        chk("R7 relocked", status_now(), 16'h0);
        wr_reg(4'd8, 16'h0001);
        @(negedge clk); @(negedge clk);
        chk("R7 keys cleared", status_now(), 16'h0);

        // R4: one-word mismatches
        run_compare(pw ^ {16'h0001, 112'h0});
        chk("R4 top word wrong", status_now(), 16'h0);
        run_compare(pw ^ {112'h0, 16'h8000});
        chk("R4 bottom word wrong", status_now(), 16'h0);

        // R6: request during fetch ignored
        load_key(pw);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 16'h0001;
        @(negedge clk);
        chk("R6 fetch after first request", pw_rd, 1'b1);
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R6 request in fetch ignored", pw_rd, 1'b0);
        @(negedge clk);
        chk("R6 no second fetch", pw_rd, 1'b0);
        chk("R6 compare done", status_now(), 16'h1);
        wr_reg(4'd8, 16'h0002);

        // R6: request in evaluation accepted
        load_key(pw);
        wr_reg(4'd8, 16'h0001);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 16'h0001;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R6 eval request accepted", pw_rd, 1'b1);
        @(negedge clk); @(negedge clk);
        wr_reg(4'd8, 16'h0002);

        // R7: relock in evaluation cycle wins
        load_key(pw);
        wr_reg(4'd8, 16'h0001);
        wr_reg(4'd8, 16'h0002);
        @(negedge clk);
        chk("R7 relock during eval", status_now(), 16'h0);
        // R7: both bits in one write
        load_key(pw);
        wr_reg(4'd8, 16'h0003);
        chk("R7 both bits no fetch", pw_rd, 1'b0);
        @(negedge clk); @(negedge clk);
        chk("R7 both bits locked", status_now(), 16'h0);

        // R5: erased password
        pw_data = '1;
        run_compare({$urandom(), $urandom(), $urandom(), $urandom()});
        chk("R5 erased unlocks", status_now(), 16'h1);
        wr_reg(4'd8, 16'h0002);
        pw_data = pw;

        // R8/R9/R10: boundaries while locked
        bnd = '{22'h007FFF, 22'h008000, 22'h008FFF, 22'h009000, 22'h009FFF, 22'h00A000,
                22'h3D77FF, 22'h3D7800, 22'h3D7BFF, 22'h3D7C00, 22'h3D7FFF, 22'h3D8000,
                22'h3F7FFF, 22'h3F8000, 22'h000000, 22'h3FFFFF};
        for (int i = 0; i < 16; i++) begin
            check_access(bnd[i], 1'b1, 1'b0, 1'b0, "R8 R9 boundary locked");
            check_access(bnd[i], 1'b1, 1'b1, 1'b0, "R10 secure origin");
        end

        // random mix
        for (int it = 0; it < 30; it++) begin
            pw = {$urandom(), $urandom(), $urandom(), $urandom()};
            pw_data = pw;
            exp_unl = $urandom_range(0, 1);
            k = pw;
            if (!exp_unl) k[($urandom_range(0, 7))*16 +: 16] ^= 16'(1 + $urandom_range(0, 16'hFFFE));
            run_compare(k);
            chk(exp_unl ? "R3 random match" : "R4 random mismatch", status_now(), {15'h0, exp_unl});
            for (int j = 0; j < 6; j++) begin
                logic [21:0] a;
                a = ($urandom_range(0, 1) != 0) ? bnd[$urandom_range(0, 15)]
                                                : 22'($urandom());
                check_access(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                             exp_unl, "R9 R10 random access");
            end
            wr_reg(4'd8, 16'h0002);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule